// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a clocked host to an external asynchronous static RAM of 128K locations by 8 bits. The host issues one transfer at a time through a request/acknowledge port carrying a 17-bit address, a write flag and a byte of write data. A read byte is returned with the acknowledge. On the memory side the block drives the address, a low-true and a high-true chip enable, a low-true output enable and a low-true write enable. The shared data bus appears as three signals: an outgoing byte, a drive-enable for the pad buffer and an incoming byte.

All memory timing is set by parameters given in clock cycles. The integrator picks each count so that, at the clock period in use, it covers the memory's nanosecond figure, rounding up. Any count set below 1 is treated as 1.

A write uses a write-enable-controlled cycle with output enable held high. The write first spends a turnaround window with write enable low and the bus undriven. The block then drives data for the setup window. Write enable rises while both chip enables are still active, which ends the write on that edge. The block keeps the memory selected for one more cycle before acknowledging.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever no transfer is in progress: mem_ce_n_o=1, mem_ce_o=0, mem_oe_n_o=1, mem_we_n_o=1, mem_dq_oe_o=0 and ack_o=0.
- R2: A read is accepted in a cycle where req_i=1 and we_i=0 while idle. Starting the next cycle, for exactly RD_CYCLES cycles, the block drives mem_ce_n_o=0, mem_ce_o=1, mem_oe_n_o=0 and mem_we_n_o=1.
- R3: Read data is sampled from mem_dq_i on the last of the RD_CYCLES read cycles. It appears on rdata_o in the following cycle, in which ack_o=1.
- R4: A write is accepted in a cycle where req_i=1 and we_i=1 while idle. Starting the next cycle, mem_we_n_o is 0 for exactly TURN_CYCLES+WSETUP_CYCLES cycles with both enables active. mem_oe_n_o stays 1 for the whole write.
- R5: mem_dq_oe_o is 1 only while mem_we_n_o=0. It rises after the first TURN_CYCLES write-enable-low cycles and stays high for exactly WSETUP_CYCLES cycles up to the cycle before write enable rises. mem_dq_o then carries the accepted wdata_i.
- R6: In the cycle where mem_we_n_o returns to 1, both chip enables are still active. The next cycle has ack_o=1 with the memory deselected.
- R7: ack_o is high for exactly one cycle. A request present in the acknowledge cycle is ignored there and accepted in the following cycle.
- R8: mem_addr_o equals the accepted address and stays unchanged for every cycle the memory is selected.
- R9: mem_dq_oe_o is never 1 in a cycle where mem_oe_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Host address |
| wdata_i | input | 8 | Host write byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read byte, valid with ack_o |
| mem_addr_o | output | 17 | Memory address lines |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_ce_o | output | 1 | Chip enable, active high |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Byte driven onto the data bus |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Byte read from the data bus |

## Verification
The memory model returns a junk byte until output enable has been low for the full access count. A controller that samples early therefore returns the wrong byte.

The bench counts write-enable-low cycles and the offset of the first drive cycle within them. A design that drives data during the turnaround window, or drops write enable before the setup window ends, shows up as a wrong count or offset. A write that releases the chip enables with write enable, or drives the bus during a read, is caught at the write-end and conflict monitors.

A request held high through the acknowledge exposes a design that starts a second transfer in the acknowledge cycle or stretches the acknowledge.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WDATA,
    ST_WEND,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic drive;
    logic ack;
  } strobe_t;

  function automatic strobe_t decode(state_e s);
    strobe_t r;
    r = '0;
    unique case (s)
      ST_READ:  begin r.sel = 1'b1; r.oe = 1'b1; end
      ST_TURN:  begin r.sel = 1'b1; r.we = 1'b1; end
      ST_WDATA: begin r.sel = 1'b1; r.we = 1'b1; r.drive = 1'b1; end
      ST_WEND:  r.sel = 1'b1;
      ST_DONE:  r.ack = 1'b1;
      default:  ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_N   = 1,
  parameter int TURN_N = 1,
  parameter int WSU_N  = 1,
  parameter int CNT_W  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output strobe_t          strobe_o
);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_N - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_N - 1);
  localparam logic [CNT_W-1:0] WSU_LD  = CNT_W'(WSU_N - 1);

  state_e  state_q, state_d;
  strobe_t strobe_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        load_o   = 1'b1;
        if (we_i) begin
          state_d    = ST_TURN;
          load_val_o = TURN_LD;
        end else begin
          state_d    = ST_READ;
          load_val_o = RD_LD;
        end
      end
      ST_READ: if (zero_i) begin
        capture_o = 1'b1;
        state_d   = ST_DONE;
      end
      ST_TURN: if (zero_i) begin
        state_d    = ST_WDATA;
        load_o     = 1'b1;
        load_val_o = WSU_LD;
      end
      ST_WDATA: if (zero_i) state_d = ST_WEND;
      ST_WEND:  state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state so memory pins never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      strobe_q <= '0;
    end else begin
      state_q  <= state_d;
      strobe_q <= decode(state_d);
    end
  end

  assign strobe_o = strobe_q;

endmodule

// File: rtl/sram_ctrl_datapath.sv
`timescale 1ns/1ps
module sram_ctrl_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= mem_dq_i;
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int RD_CYCLES     = 2,
  parameter int TURN_CYCLES   = 1,
  parameter int WSETUP_CYCLES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RD_N   = (RD_CYCLES < 1) ? 1 : RD_CYCLES;
  localparam int TURN_N = (TURN_CYCLES < 1) ? 1 : TURN_CYCLES;
  localparam int WSU_N  = (WSETUP_CYCLES < 1) ? 1 : WSETUP_CYCLES;
  localparam int MAX_A  = (RD_N > TURN_N) ? RD_N : TURN_N;
  localparam int MAX_N  = (MAX_A > WSU_N) ? MAX_A : WSU_N;
  localparam int CNT_W  = (MAX_N > 1) ? $clog2(MAX_N) : 1;

  logic             load, zero, accept, capture;
  logic [CNT_W-1:0] load_val;
  strobe_t          strobe;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  sram_ctrl_fsm #(
    .RD_N   (RD_N),
    .TURN_N (TURN_N),
    .WSU_N  (WSU_N),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .strobe_o   (strobe)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rdata_o)
  );

  assign mem_ce_n_o  = ~strobe.sel;
  assign mem_ce_o    = strobe.sel;
  assign mem_oe_n_o  = ~strobe.oe;
  assign mem_we_n_o  = ~strobe.we;
  assign mem_dq_oe_o = strobe.drive;
  assign ack_o       = strobe.ack;

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic              mem_ce_n_o,
  input logic              mem_ce_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              mem_dq_oe_o,
  input logic [ADDR_W-1:0] mem_addr_o
);

  logic selected;
  assign selected = !mem_ce_n_o && mem_ce_o;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !selected |-> (mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o));

  assert_read_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (selected && mem_we_n_o));

  assert_write_oe_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (selected && mem_oe_n_o));

  assert_drive_in_we_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> !mem_we_n_o);

  assert_write_end_selected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> selected);

  assert_ack_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_ack_deselected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !selected);

  assert_addr_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (selected && $past(selected)) |-> $stable(mem_addr_o));

  assert_no_contention_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_n_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_o       (ack_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_ce_o    (mem_ce_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;

  localparam int RD   = 3;
  localparam int TURN = 2;
  localparam int WSU  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ack;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic        ce_n, ce, oe_n, we_n, dq_oe;
  logic [7:0]  dq_o, dq_i;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sram_ctrl #(
    .RD_CYCLES(RD), .TURN_CYCLES(TURN), .WSETUP_CYCLES(WSU)
  ) u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .mem_addr_o(mem_addr),
    .mem_ce_n_o(ce_n), .mem_ce_o(ce), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  function automatic logic [7:0] pattern(input logic [16:0] a);
    return a[7:0] ^ a[16:9];
  endfunction

  // memory model: junk until output enable has been low RD cycles
  int oe_age = 0;
  always @(posedge clk) oe_age <= oe_n ? 0 : oe_age + 1;
  assign dq_i = (!oe_n && oe_age >= RD - 1) ? pattern(mem_addr) : 8'hEE;

  // per-transfer monitor
  int rd_cnt, we_cnt, dq_cnt, dq_first, conflicts, addr_err, end_unsel;
  logic [16:0] cur_addr, wr_addr;
  logic [7:0]  wr_data;
  logic        prev_we_n = 1'b1;

  always @(negedge clk) begin
    if (!oe_n) rd_cnt++;
    if (!we_n) begin we_cnt++; wr_addr = mem_addr; end
    if (dq_oe) begin
      dq_cnt++;
      wr_data = dq_o;
      if (dq_first == 0) dq_first = we_cnt;
    end
    if (dq_oe && !oe_n) conflicts++;
    if (!ce_n && ce && mem_addr != cur_addr) addr_err++;
    if (we_n && !prev_we_n && !(!ce_n && ce)) end_unsel++;
    prev_we_n = we_n;
  end

  task automatic clear_mon(input logic [16:0] a);
    rd_cnt = 0; we_cnt = 0; dq_cnt = 0; dq_first = 0;
    conflicts = 0; addr_err = 0; end_unsel = 0; cur_addr = a;
  endtask

  task automatic chk(input string r, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk("R1", {tag, " ce_n"}, int'(ce_n), 1);
    chk("R1", {tag, " ce"}, int'(ce), 0);
    chk("R1", {tag, " oe_n"}, int'(oe_n), 1);
    chk("R1", {tag, " we_n"}, int'(we_n), 1);
    chk("R1", {tag, " dq_oe"}, int'(dq_oe), 0);
    chk("R1", {tag, " ack"}, int'(ack), 0);
  endtask

  task automatic run_txn(input logic w, input logic [16:0] a, input logic [7:0] d);
    int lat;
    clear_mon(a);
    req = 1'b1; we = w; addr = a; wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!ack && lat < 100);
    req = 1'b0;
    chk("R6", "ack deselected", int'(ce_n), 1);
    chk("R8", "address stable", addr_err, 0);
    chk("R9", "bus contention", conflicts, 0);
    if (w) begin
      chk("R6", "ack latency write", lat, TURN + WSU + 2);
      chk("R4", "we low cycles", we_cnt, TURN + WSU);
      chk("R4", "oe low during write", rd_cnt, 0);
      chk("R5", "drive cycles", dq_cnt, WSU);
      chk("R5", "first drive offset", dq_first, TURN + 1);
      chk("R5", "write data", int'(wr_data), int'(d));
      chk("R8", "write address", int'(wr_addr), int'(a));
      chk("R6", "write end deselected", end_unsel, 0);
    end else begin
      chk("R3", "ack latency read", lat, RD + 1);
      chk("R2", "oe low cycles", rd_cnt, RD);
      chk("R2", "we low during read", we_cnt, 0);
      chk("R3", "read data", int'(rdata), int'(pattern(a)));
    end
    @(negedge clk);
    chk("R7", "ack one cycle", int'(ack), 0);
    chk_idle("post");
  endtask

  localparam logic [25:0] VEC [0:7] = '{
    {1'b1, 17'h1_0000, 8'hA5},
    {1'b0, 17'h1_0000, 8'h00},
    {1'b1, 17'h0_0000, 8'h3C},
    {1'b0, 17'h1_FFFF, 8'h00},
    {1'b0, 17'h0_0001, 8'h00},
    {1'b1, 17'h1_FFFF, 8'hFF},
    {1'b0, 17'h0_AAAA, 8'h00},
    {1'b1, 17'h0_5555, 8'h01}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    clear_mon('0);
    repeat (3) @(negedge clk);
    chk_idle("reset R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("after reset R1");

    for (int i = 0; i < 8; i++)
      run_txn(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);

    // R7: request held through ack, changed to a read in the ack cycle
    clear_mon(17'h0_0123);
    req = 1'b1; we = 1'b1; addr = 17'h0_0123; wdata = 8'h5A;
    begin
      int lat = 0;
      do begin @(negedge clk); lat++; end while (!ack && lat < 100);
      chk("R7", "ack latency first", lat, TURN + WSU + 2);
    end
    we = 1'b0; addr = 17'h1_0F0F;
    @(negedge clk);
    chk("R7", "ack single cycle", int'(ack), 0);
    chk("R7", "not accepted in ack cycle", int'(ce_n), 1);
    @(negedge clk);
    chk("R7", "accepted next cycle oe_n", int'(oe_n), 0);
    chk("R8", "new address", int'(mem_addr), int'(17'h1_0F0F));
    begin
      int lat = 1;
      while (!ack && lat < 100) begin @(negedge clk); lat++; end
      chk("R3", "back-to-back latency", lat, RD + 1);
      chk("R3", "back-to-back data", int'(rdata), int'(pattern(17'h1_0F0F)));
    end
    req = 1'b0;
    repeat (2) @(negedge clk);
    chk_idle("final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule